// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

The block is a count-down timer for a local interrupt unit. Its clock is the bus clock, and that clock passes through a programmable power-of-two prescaler. Software can write three registers: a divide configuration, an initial count and a timer entry. The timer entry holds an interrupt vector, a mask bit and a mode bit that selects one-shot or periodic operation. A write to the initial count loads the running counter and starts it. Each divided tick lowers the counter by one. When a tick takes the counter from one to zero, the timer has expired.

On expiry the block raises a one-cycle request that carries the entry's vector, unless the entry is masked. In one-shot mode the counter stays at zero after expiry. In periodic mode it reloads the initial count and keeps running. A software-disable input forces the entry's mask bit on for as long as it is held. All registers and the live count can be read back on dedicated outputs.

Top module: `cdt_timer`

## Requirements
- R1: A divide-configuration write (`wr_sel` = 0) keeps only data bits 3, 1 and 0. `cfg_rd` shows those bits in place, and every other bit reads as 0.
- R2: The divisor is 2 raised to ((({cfg[3], cfg[1:0]}) + 1) mod 8). Code 0 divides by 2, code 0b1011 divides by 1, and code 0b1010 divides by 128. A configuration write takes effect from the next cycle.
- R3: An initial-count write (`wr_sel` = 1) shows the written value on `init_rd` and on `cur_count` in the next cycle, and it restarts the prescaler. After that, `cur_count` falls by one every divisor cycles.
- R4: In one-shot mode (entry bit 17 = 0), `irq_valid` is seen exactly count × divisor + 1 cycles after the cycle in which the initial count was written. After expiry `cur_count` holds at 0 and no further request follows.
- R5: In periodic mode (entry bit 17 = 1), expiry reloads `cur_count` from the initial count. The requests then repeat every count × divisor cycles.
- R6: A timer-entry write (`wr_sel` = 2) stores the vector from bits 7:0, the mask from bit 16 and the mode from bit 17. `lvt_rd` shows them at those positions with all other bits zero. A request lasts one cycle for each expiry and carries the vector on `irq_vector`. There is no request while the mask is set.
- R7: While `sw_disable` is high, the mask bit is forced to 1 in the next cycle. This also holds for an entry write in that same cycle that tries to clear the mask.
- R8: After reset the initial count, the current count and the divide configuration are 0, and the entry reads 0x00010000 (masked). No request is pending.
- R9: An initial count of 0 never produces a request, and `cur_count` stays at 0.
- R10: If an initial-count write falls in the cycle in which the counter would expire, the restart wins. No request is issued and the new count is loaded.
- R11: If a timer-entry write falls in the expiry cycle, the request uses the entry as it was before the write: its mask and its vector.
- Write select 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 divide, 1 initial count, 2 timer entry, 3 none |
| wr_data | input | 32 | Write data |
| sw_disable | input | 1 | Software disable; forces the entry mask |
| cur_count | output | 32 | Live counter value |
| init_rd | output | 32 | Initial-count register |
| cfg_rd | output | 32 | Divide-configuration register |
| lvt_rd | output | 32 | Timer entry: vector 7:0, mask 16, periodic 17 |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
Expiry can coincide with a register write in the same cycle. The bench provokes this directly in two ways. It rewrites the initial count in the exact cycle in which the counter shows one with a divisor of one. It also rewrites the timer entry, with a new vector and the mask set, in that same cycle. In the first case the outputs must show no request and the new count. In the second case they must show a request that carries the old vector. The random phase mixes writes, disable pulses and every divisor code, and it compares every cycle against a bench-side timing model, so further collisions of this kind are judged as they happen.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int VEC_W    = 8;
    localparam int CFG_W    = 4;
    localparam int SHIFT_W  = 3;
    localparam int MASK_BIT = 16;
    localparam int MODE_BIT = 17;

    // writable bits of the divide configuration
    localparam logic [CFG_W-1:0] CFG_KEEP = 4'b1011;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_INIT = 2'd1,
        SEL_LVT  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } lvt_t;

    localparam lvt_t LVT_RESET = '{periodic: 1'b0, masked: 1'b1, vector: '0};

    // shift amount of the power-of-two divisor; wraps modulo 2**SHIFT_W
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [CFG_W-1:0] cfg);
        return SHIFT_W'({cfg[3], cfg[1:0]}) + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sw_disable,
    output logic [CFG_W-1:0] cfg_q,
    output lvt_t             lvt_q,
    output logic [CNT_W-1:0] init_q,
    output logic             load
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        lvt_t             lvt;
        logic [CNT_W-1:0] init;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        load = wr_en && (wsel_e'(wr_sel) == SEL_INIT);
        if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_DIV:  r_d.cfg = wr_data[CFG_W-1:0] & CFG_KEEP;
                SEL_INIT: r_d.init = wr_data;
                SEL_LVT: begin
                    r_d.lvt.vector   = wr_data[VEC_W-1:0];
                    r_d.lvt.masked   = wr_data[MASK_BIT];
                    r_d.lvt.periodic = wr_data[MODE_BIT];
                end
                default: ;
            endcase
        end
        // disable overrides any unmask attempted in the same cycle
        if (sw_disable) begin
            r_d.lvt.masked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg  <= '0;
            r_q.lvt  <= LVT_RESET;
            r_q.init <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_q  = r_q.cfg;
    assign lvt_q  = r_q.lvt;
    assign init_q = r_q.init;

endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               load,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W:0]   lim;

    always_comb begin
        lim   = (PRE_W + 1)'(1) << shift;
        lim   = lim - 1'b1;
        // >= so that a smaller divisor chosen mid-run takes effect at once
        tick  = run && !load && ({1'b0, pre_q} >= lim);
        pre_d = (load || !run || tick) ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/cdt_count.sv
module cdt_count
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] init,
    input  lvt_t             lvt,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vec
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } cnt_t;

    cnt_t c_d, c_q;
    logic at_one;
    logic fire;

    always_comb begin
        c_d    = c_q;
        at_one = (c_q.count == CNT_W'(1));
        fire   = tick && at_one;
        if (load) begin
            c_d.count = load_val;
        end else if (tick) begin
            if (at_one) begin
                c_d.count = lvt.periodic ? init : '0;
            end else begin
                c_d.count = c_q.count - 1'b1;
            end
        end
        c_d.irq = fire && !lvt.masked;
        c_d.vec = c_d.irq ? lvt.vector : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count   = c_q.count;
    assign run     = (c_q.count != '0);
    assign irq     = c_q.irq;
    assign irq_vec = c_q.vec;

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sw_disable,
    output logic [CNT_W-1:0] cur_count,
    output logic [CNT_W-1:0] init_rd,
    output logic [CNT_W-1:0] cfg_rd,
    output logic [CNT_W-1:0] lvt_rd,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);

    logic [CFG_W-1:0]   cfg_q;
    lvt_t               lvt_q;
    logic [CNT_W-1:0]   init_q;
    logic               load;
    logic               run;
    logic               tick;
    logic [SHIFT_W-1:0] shift;

    cdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .sw_disable (sw_disable),
        .cfg_q      (cfg_q),
        .lvt_q      (lvt_q),
        .init_q     (init_q),
        .load       (load)
    );

    assign shift = div_shift(cfg_q);

    cdt_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .load  (load),
        .shift (shift),
        .tick  (tick)
    );

    cdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data),
        .tick     (tick),
        .init     (init_q),
        .lvt      (lvt_q),
        .count    (cur_count),
        .run      (run),
        .irq      (irq_valid),
        .irq_vec  (irq_vector)
    );

    always_comb begin
        init_rd                = init_q;
        cfg_rd                 = CNT_W'(cfg_q);
        lvt_rd                 = '0;
        lvt_rd[VEC_W-1:0]      = lvt_q.vector;
        lvt_rd[MASK_BIT]       = lvt_q.masked;
        lvt_rd[MODE_BIT]       = lvt_q.periodic;
    end

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             sw_disable,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] init_rd,
    input logic [CNT_W-1:0] cfg_rd,
    input logic [CNT_W-1:0] lvt_rd,
    input logic             irq_valid
);

    logic init_wr;
    assign init_wr = wr_en && (wr_sel == 2'd1);

    // R1
    cfg_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd[CNT_W-1:4] == '0) && !cfg_rd[2]);

    // R7
    disable_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_disable |=> lvt_rd[16]);

    // R6
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(lvt_rd[16]));

    // R3
    load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (cur_count == init_rd));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_wr |=> (cur_count == $past(cur_count)) ||
                     (cur_count == $past(cur_count) - 1'b1) ||
                     (cur_count == $past(init_rd)));

    // R4
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !init_wr) |=> (cur_count == '0));

    // R9
    fire_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ($past(cur_count) == CNT_W'(1)));

endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .sw_disable (sw_disable),
    .cur_count  (cur_count),
    .init_rd    (init_rd),
    .cfg_rd     (cfg_rd),
    .lvt_rd     (lvt_rd),
    .irq_valid  (irq_valid)
);

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        sw_disable;
    logic [31:0] cur_count, init_rd, cfg_rd, lvt_rd;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    always #4 clk = ~clk;

    cdt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sw_disable(sw_disable), .cur_count(cur_count),
        .init_rd(init_rd), .cfg_rd(cfg_rd), .lvt_rd(lvt_rd),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    int n_tests = 0, n_fail = 0, cyc = 0, last_irq = -1, irq_total = 0;
    logic [7:0] last_vec;
    bit done = 0;

    // expected-state model
    logic [3:0]  m_cfg;
    logic [31:0] m_init, m_cnt;
    int          m_pre;
    logic        m_mask, m_per, m_irq;
    logic [7:0]  m_vec, m_ivec;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int mdiv(input logic [3:0] c);
        return 1 << ((int'({c[3], c[1:0]}) + 1) % 8);
    endfunction

    task automatic model_reset();
        m_cfg = 0; m_init = 0; m_cnt = 0; m_pre = 0;
        m_mask = 1; m_per = 0; m_vec = 0; m_irq = 0; m_ivec = 0;
    endtask

    task automatic step(input logic en, input logic [1:0] sel,
                        input logic [31:0] data, input logic dis);
        int   dv;
        logic ld, tk, fire;
        @(negedge clk);
        cyc++;
        chk("R3", "count", cur_count, m_cnt);
        chk("R3", "init", init_rd, m_init);
        chk("R1", "cfg", cfg_rd, {28'd0, m_cfg});
        chk("R6", "entry", lvt_rd, {14'd0, m_per, m_mask, 8'd0, m_vec});
        chk("R6", "irq", 32'(irq_valid), 32'(m_irq));
        if (m_irq) chk("R6", "vector", 32'(irq_vector), 32'(m_ivec));
        if (irq_valid) begin
            last_irq = cyc; irq_total++; last_vec = irq_vector;
        end
        wr_en = en; wr_sel = sel; wr_data = data; sw_disable = dis;
        @(posedge clk);
        dv   = mdiv(m_cfg);
        ld   = en && sel == 2'd1;
        tk   = !ld && m_cnt != 0 && (m_pre >= dv - 1);
        fire = tk && m_cnt == 1;
        m_irq  = fire && !m_mask;
        m_ivec = m_irq ? m_vec : 8'd0;
        m_pre  = (ld || m_cnt == 0 || tk) ? 0 : m_pre + 1;
        if (ld) m_cnt = data;
        else if (tk) m_cnt = (m_cnt == 1) ? (m_per ? m_init : 32'd0) : m_cnt - 1;
        if (ld) m_init = data;
        if (en && sel == 2'd0) m_cfg = data[3:0] & 4'b1011;
        if (en && sel == 2'd2) begin
            m_vec = data[7:0]; m_mask = data[16]; m_per = data[17];
        end
        if (dis) m_mask = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, 32'd0, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int w, base, p1;
        void'($urandom(32'd4242));
        rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; sw_disable = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R8 reset values
        chk("R8", "count", cur_count, 0);
        chk("R8", "init", init_rd, 0);
        chk("R8", "cfg", cfg_rd, 0);
        chk("R8", "entry", lvt_rd, 32'h0001_0000);
        chk("R8", "irq", 32'(irq_valid), 0);

        // R1 only bits 3,1,0 kept
        step(1, 2'd0, 32'hFFFF_FFFF, 0); #2;
        chk("R1", "cfg mask", cfg_rd, 32'h0000_000B);

        // R2 divide by 1, R4 one-shot
        step(1, 2'd2, 32'h0000_0040, 0);
        base = irq_total;
        step(1, 2'd1, 32'd3, 0); w = cyc;
        idle(12);
        chk("R2", "div1 expiry cycle", 32'(last_irq), 32'(w + 4));
        chk("R6", "vector", 32'(last_vec), 32'h40);
        chk("R4", "one pulse", 32'(irq_total - base), 1);
        #2; chk("R4", "hold zero", cur_count, 0);

        // R2 code 0 divides by 2
        step(1, 2'd0, 32'd0, 0);
        step(1, 2'd1, 32'd4, 0); w = cyc;
        idle(14);
        chk("R2", "div2 expiry cycle", 32'(last_irq), 32'(w + 9));

        // R2 code 0b1010 divides by 128
        step(1, 2'd0, 32'hA, 0);
        step(1, 2'd1, 32'd2, 0); w = cyc;
        idle(262);
        chk("R2", "div128 expiry cycle", 32'(last_irq), 32'(w + 257));

        // R5 periodic, divide by 2
        step(1, 2'd2, 32'h0002_0041, 0);
        step(1, 2'd0, 32'd0, 0);
        step(1, 2'd1, 32'd3, 0); w = cyc;
        idle(7); p1 = last_irq;
        idle(6);
        chk("R5", "first period", 32'(p1), 32'(w + 7));
        chk("R5", "second period", 32'(last_irq), 32'(w + 13));
        chk("R6", "periodic vector", 32'(last_vec), 32'h41);

        // R9 zero count never fires
        step(1, 2'd1, 32'd0, 0);
        base = irq_total;
        idle(40);
        chk("R9", "no pulse", 32'(irq_total - base), 0);
        #2; chk("R9", "count zero", cur_count, 0);

        // R6 masked entry suppresses request
        step(1, 2'd2, 32'h0001_0042, 0);
        step(1, 2'd0, 32'hB, 0);
        base = irq_total;
        step(1, 2'd1, 32'd2, 0);
        idle(10);
        chk("R6", "masked no pulse", 32'(irq_total - base), 0);

        // R7 disable forces mask over an unmasking write
        step(1, 2'd2, 32'h0000_0043, 1); #2;
        chk("R7", "forced mask", lvt_rd, 32'h0001_0043);
        step(0, 2'd0, 32'd0, 0);
        step(1, 2'd2, 32'h0000_0043, 0);

        // R10 restart in expiry cycle wins
        step(1, 2'd1, 32'd2, 0); w = cyc;
        step(0, 2'd0, 32'd0, 0);
        step(1, 2'd1, 32'd5, 0); #2;
        chk("R10", "no pulse", 32'(irq_valid), 0);
        chk("R10", "reloaded", cur_count, 5);
        idle(8);
        chk("R10", "new expiry", 32'(last_irq), 32'(w + 8));

        // R11 entry write in expiry cycle: old entry used
        step(1, 2'd1, 32'd2, 0);
        step(0, 2'd0, 32'd0, 0);
        step(1, 2'd2, 32'h0001_0050, 0); #2;
        chk("R11", "pulse kept", 32'(irq_valid), 1);
        chk("R11", "old vector", 32'(irq_vector), 32'h43);
        idle(2);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic        en, dis;
            logic [1:0]  sel;
            logic [31:0] d;
            en  = ($urandom % 4) == 0;
            sel = 2'($urandom % 4);
            dis = ($urandom % 20) == 0;
            case (sel)
                2'd1:    d = $urandom % 24;
                2'd2:    d = $urandom & 32'h0003_00FF;
                default: d = $urandom;
            endcase
            step(en, sel, d, dis);
        end
        idle(2);
        done = 1;
        finish_run();
    end

endmodule